// File: doc/BRIEF.md
# Three-State Phase-Frequency Detector

This block compares the phase and frequency of a reference signal with the feedback signal of a digital phase-locked loop. Both signals are asynchronous to a fast system clock. Each one passes through a synchroniser, and its rising edges become single-cycle pulses. A three-state machine then drives a pump output. The pump is high while the reference is ahead, low while the feedback is ahead, and released (high impedance) once the lagging edge catches up.

The three-state pump is carried as two signals so that it stays synthesizable. `pump_en` is 1 while the pump drives, and `pump_val` gives the driven level. A separate flag, `phase_ok`, is high whenever the pump is released, and a loop can use it as a lock indicator. The block feeds a loop filter and oscillator, which sit outside it.

Top module: `tri_pfd`

## Requirements
- R1: Each input passes through SYNC_STAGES (default 2) synchroniser flops. A rising input that is first sampled at clock edge k changes the outputs just after edge k+2.
- R2: When a reference rise is detected while the pump is released, the pump drives high (pump_en=1, pump_val=1). It keeps driving high until a feedback rise is detected, and is then released.
- R3: When a feedback rise is detected while the pump is released, the pump drives low (pump_en=1, pump_val=0). It keeps driving low until a reference rise is detected, and is then released.
- R4: phase_ok is 1 exactly when pump_en is 0.
- R5: If the reference is absent and the feedback keeps toggling, the pump stays driven low without a gap after the first feedback rise.
- R6: A further rise on the same input while that input's drive state is active leaves the state unchanged. This includes a spurious extra reference rise while the pump is driving high.
- R7: When a reference rise and a feedback rise are detected in the same cycle, the pump is released, or stays released.
- R8: A synchronous active-high reset releases the pump, sets phase_ok to 1 and clears the synchronisers.
- R9: Out of lock, the pump drives high for more cycles than it drives low when the feedback is slower than the reference. When the feedback is faster, it drives low for more cycles than it drives high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_in | input | 1 | Asynchronous reference signal |
| fb_in | input | 1 | Asynchronous feedback (oscillator) signal |
| pump_en | output | 1 | 1 while the pump drives, 0 when it is released |
| pump_val | output | 1 | Driven level: 1 high, 0 low (don't-care when pump_en=0) |
| phase_ok | output | 1 | Lock flag, high while the pump is released |

## Verification
A reference rise and a feedback rise can be detected in the same cycle. The result then depends on the resolution rule, not on which edge came first. The bench provokes this by changing both inputs on the same clock, both from the released state and from each drive state. The long random run also gives many accidental coincidences. A cycle-accurate model in the bench, built from the requirements and including the synchroniser delay, judges every cycle. An assertion checks that a coincident pair always leaves the pump released.

// File: rtl/tri_pfd.sv
module tri_pfd #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_in,
  input  logic fb_in,
  output logic pump_en,
  output logic pump_val,
  output logic phase_ok
);

  localparam int W = SYNC_STAGES + 1;

  typedef enum logic [1:0] {ST_HIZ, ST_UP, ST_DN} st_t;

  logic [W-1:0] ref_sh, fb_sh;
  logic         ref_rise, fb_rise;
  st_t          st, st_nx;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_sh <= '0;
      fb_sh  <= '0;
    end else begin
      ref_sh <= {ref_sh[W-2:0], ref_in};
      fb_sh  <= {fb_sh[W-2:0], fb_in};
    end
  end

  assign ref_rise = ref_sh[W-2] & ~ref_sh[W-1];
  assign fb_rise  = fb_sh[W-2]  & ~fb_sh[W-1];

  always_comb begin
    st_nx = st;
    if (ref_rise && fb_rise)
      st_nx = ST_HIZ;
    else if (ref_rise)
      st_nx = (st == ST_DN) ? ST_HIZ : ST_UP;
    else if (fb_rise)
      st_nx = (st == ST_UP) ? ST_HIZ : ST_DN;
  end

  always_ff @(posedge clk) begin
    if (rst) st <= ST_HIZ;
    else     st <= st_nx;
  end

  assign pump_en  = (st != ST_HIZ);
  assign pump_val = (st == ST_UP);
  assign phase_ok = (st == ST_HIZ);

endmodule

module pfd_chk (
  input logic clk,
  input logic rst,
  input logic ref_rise,
  input logic fb_rise,
  input logic pump_en,
  input logic pump_val,
  input logic phase_ok
);

  AST_FLAG_MATCH: assert property (@(posedge clk) disable iff (rst) phase_ok != pump_en); // R4
  AST_RESET_HIZ: assert property (@(posedge clk) rst |=> (phase_ok && !pump_en)); // R8
  AST_UP_HOLD: assert property (@(posedge clk) disable iff (rst) (pump_en && pump_val && !fb_rise) |=> (pump_en && pump_val)); // R6
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (rst) (pump_en && !pump_val && !ref_rise) |=> (pump_en && !pump_val)); // R6
  AST_UP_RELEASE: assert property (@(posedge clk) disable iff (rst) (pump_en && pump_val && fb_rise) |=> !pump_en); // R2
  AST_DN_RELEASE: assert property (@(posedge clk) disable iff (rst) (pump_en && !pump_val && ref_rise) |=> !pump_en); // R3
  AST_BOTH_HIZ: assert property (@(posedge clk) disable iff (rst) (ref_rise && fb_rise) |=> !pump_en); // R7
  AST_REF_PULSE: assert property (@(posedge clk) disable iff (rst) ref_rise |=> !ref_rise); // R1
  AST_FB_PULSE: assert property (@(posedge clk) disable iff (rst) fb_rise |=> !fb_rise); // R1

endmodule

bind tri_pfd pfd_chk u_chk (
  .clk(clk), .rst(rst), .ref_rise(ref_rise), .fb_rise(fb_rise),
  .pump_en(pump_en), .pump_val(pump_val), .phase_ok(phase_ok)
);

// File: tb/sim_tri_pfd.sv
`timescale 1ns/1ps
module sim_tri_pfd;

  logic clk = 0, rst = 1, ref_in = 0, fb_in = 0;
  logic pump_en, pump_val, phase_ok;
  int nchk = 0, nerr = 0;
  int n_hi, n_lo;
  bit done = 0;

  // expected state: 0 released, 1 high, 2 low
  int es = 0;
  logic [3:0] hr = '0, hf = '0;

  tri_pfd u0 (.clk(clk), .rst(rst), .ref_in(ref_in), .fb_in(fb_in),
              .pump_en(pump_en), .pump_val(pump_val), .phase_ok(phase_ok));

  always #10 clk = ~clk;

  function automatic int nxt(int s, bit re, bit fe);
    if (re && fe) return 0;
    if (re) return (s == 2) ? 0 : 1;
    if (fe) return (s == 1) ? 0 : 2;
    return s;
  endfunction

  task automatic chk(string tag, bit cond, string act, string exp);
    nchk++;
    if (!cond) begin
      nerr++;
      $display("FAIL %s: actual %s expected %s at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit r, bit f, bit rs, string tag);
    bit e_en, e_val, ok;
    @(negedge clk);
    e_en = (es != 0); e_val = (es == 1);
    ok = (pump_en === e_en) && (phase_ok === !e_en) && (!e_en || pump_val === e_val);
    chk(tag, ok, $sformatf("en=%b val=%b ok=%b", pump_en, pump_val, phase_ok),
        $sformatf("en=%b val=%b ok=%b", e_en, e_val, !e_en));
    if (pump_en === 1'b1 && pump_val === 1'b1) n_hi++;
    if (pump_en === 1'b1 && pump_val === 1'b0) n_lo++;
    ref_in = r; fb_in = f; rst = rs;
    if (rs) begin
      hr = '0; hf = '0; es = 0;
    end else begin
      hr = {hr[2:0], r}; hf = {hf[2:0], f};
      es = nxt(es, hr[2] & ~hr[3], hf[2] & ~hf[3]);
    end
  endtask

  task automatic hold(int n, string tag);
    for (int i = 0; i < n; i++) step(ref_in, fb_in, 1'b0, tag);
  endtask

  task automatic periodic(int pr, int pf, int n, string tag);
    for (int i = 0; i < n; i++)
      step(pr > 0 ? ((i % pr) < pr / 2) : 1'b0, (i % pf) < pf / 2, 1'b0, tag);
  endtask

  initial begin
    #(20ns * 200000);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    // R8 reset state
    for (int i = 0; i < 4; i++) step(0, 0, 1, "R8");
    step(0, 0, 0, "R8");
    chk("R8", phase_ok === 1 && pump_en === 0, $sformatf("%b%b", phase_ok, pump_en), "10");

    // R1 latency and R2 reference first
    step(1, 0, 0, "R1");
    step(1, 0, 0, "R1");
    step(1, 0, 0, "R1");
    chk("R1", pump_en === 0, $sformatf("%b", pump_en), "0");
    step(1, 0, 0, "R2");
    chk("R2", pump_en === 1 && pump_val === 1, $sformatf("%b%b", pump_en, pump_val), "11");
    hold(4, "R2");
    step(0, 0, 0, "R6"); step(1, 0, 0, "R6");
    hold(5, "R6");
    chk("R6", pump_en === 1 && pump_val === 1, $sformatf("%b%b", pump_en, pump_val), "11");
    step(1, 1, 0, "R2"); hold(3, "R2");
    chk("R2", pump_en === 0 && phase_ok === 1, $sformatf("%b%b", pump_en, phase_ok), "01");

    // R3 feedback first
    step(0, 0, 0, "R3"); hold(3, "R3");
    step(0, 1, 0, "R3"); hold(3, "R3");
    chk("R3", pump_en === 1 && pump_val === 0, $sformatf("%b%b", pump_en, pump_val), "10");
    step(0, 0, 0, "R6"); step(0, 1, 0, "R6"); hold(4, "R6");
    chk("R6", pump_en === 1 && pump_val === 0, $sformatf("%b%b", pump_en, pump_val), "10");
    step(1, 1, 0, "R3"); hold(3, "R3");
    chk("R3", pump_en === 0, $sformatf("%b", pump_en), "0");

    // R7 coincident edges from released and from each drive state
    step(0, 0, 0, "R7"); hold(3, "R7");
    step(1, 1, 0, "R7"); hold(3, "R7");
    chk("R7", pump_en === 0, $sformatf("%b", pump_en), "0");
    step(0, 0, 0, "R7"); hold(3, "R7");
    step(1, 0, 0, "R7"); hold(2, "R7");
    step(0, 0, 0, "R7"); hold(3, "R7");
    step(1, 1, 0, "R7"); hold(3, "R7");
    chk("R7", pump_en === 0, $sformatf("%b", pump_en), "0");
    step(0, 0, 0, "R7"); hold(3, "R7");
    step(0, 1, 0, "R7"); hold(2, "R7");
    step(0, 0, 0, "R7"); hold(3, "R7");
    step(1, 1, 0, "R7"); hold(3, "R7");
    chk("R7", pump_en === 0, $sformatf("%b", pump_en), "0");

    // R8 mid-run reset while driving
    step(0, 0, 0, "R8"); hold(3, "R8");
    step(1, 0, 0, "R8"); hold(4, "R8");
    step(0, 0, 1, "R8"); step(0, 0, 0, "R8");
    chk("R8", pump_en === 0 && phase_ok === 1, $sformatf("%b%b", pump_en, phase_ok), "01");
    hold(3, "R8");

    // R5 feedback only
    periodic(0, 8, 6, "R5");
    n_hi = 0; n_lo = 0;
    periodic(0, 8, 200, "R5");
    chk("R5", n_lo == 200 && n_hi == 0, $sformatf("lo=%0d hi=%0d", n_lo, n_hi), "lo=200 hi=0");

    // R9 slow and fast feedback
    step(0, 0, 1, "R9"); step(0, 0, 0, "R9");
    n_hi = 0; n_lo = 0;
    periodic(20, 30, 600, "R9");
    chk("R9", n_hi > n_lo, $sformatf("hi=%0d lo=%0d", n_hi, n_lo), "hi>lo");
    step(0, 0, 1, "R9"); step(0, 0, 0, "R9");
    n_hi = 0; n_lo = 0;
    periodic(30, 20, 600, "R9");
    chk("R9", n_lo > n_hi, $sformatf("hi=%0d lo=%0d", n_hi, n_lo), "lo>hi");

    // R6 random edges on both inputs, judged every cycle by the model
    for (int i = 0; i < 4000; i++) begin
      bit r, f;
      r = ref_in; f = fb_in;
      if ($urandom_range(0, 4) == 0) r = ~r;
      if ($urandom_range(0, 4) == 0) f = ~f;
      step(r, f, 1'b0, "R6");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule